// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit

This block is a shared arithmetic engine for 32-bit two's complement integers. A multiply takes the low-word input as the multiplicand and a separate operand as the multiplier, and produces a full 64-bit signed product on the high and low result words. A divide treats the high and low input words together as one 64-bit signed dividend, divides it by the 32-bit operand, and returns the quotient on the low result word and the remainder on the high result word. Division truncates toward zero, and the remainder carries the sign of the dividend.

Control is a plain start/busy/done exchange. A start pulse seen while the unit is idle is accepted. The unit then runs a radix-2 loop of one step per operand bit and finishes with one cycle of sign correction and write-back. It raises done for exactly one cycle and drops busy in the same cycle. A start seen while busy is dropped. A multiply updates a carry flag and an overflow flag, and the two always agree. A divide leaves both flags as they were. A divide by zero, or a divide whose quotient does not fit in 32 signed bits, raises the trap output together with done and leaves the result words unchanged.

Top module: `mdu_signed`

## Requirements
- R1: A multiply sets {res_hi,res_lo} to the 64-bit two's complement product of src_lo and src_opd, fully sign-extended into res_hi (for example -2 x 2 gives res_hi 0xFFFFFFFF and res_lo 0xFFFFFFFC). src_hi has no effect on a multiply.
- R2: After a multiply, flag_cf and flag_of are both 1 when res_hi is not the sign extension of res_lo[31], and both 0 otherwise. The two flags are always equal.
- R3: A divide (op_div=1) takes {src_hi,src_lo} as a signed 64-bit dividend and src_opd as a signed divisor. It writes the quotient, truncated toward zero, to res_lo and the remainder, with the sign of the dividend, to res_hi.
- R4: A divide whose quotient lies outside -2^31..2^31-1 raises div_trap in the done cycle and leaves res_hi and res_lo unchanged.
- R5: A divide with src_opd = 0 raises div_trap in the done cycle and leaves res_hi and res_lo unchanged.
- R6: The clock edge that accepts start sets busy. done is high for exactly one cycle, starting 33 clock edges after the accepting edge. busy falls in that same cycle, and div_trap is never high without done.
- R7: start is ignored while busy is high. The running operation's result and timing do not change.
- R8: A divide leaves flag_cf and flag_of unchanged, and a multiply never raises div_trap.
- R9: After reset, busy, done, div_trap, flag_cf, flag_of, res_hi and res_lo are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; accepted only while idle |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| src_hi | input | 32 | Upper dividend word (divide only) |
| src_lo | input | 32 | Multiplicand, or lower dividend word |
| src_opd | input | 32 | Multiplier, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Product upper word, or remainder |
| res_lo | output | 32 | Product lower word, or quotient |
| flag_cf | output | 1 | Multiply result needs more than 32 bits |
| flag_of | output | 1 | Same condition as flag_cf |
| div_trap | output | 1 | Divide error, valid with done |

## Verification
The bench targets the sign and magnitude edges. These include products with a negative result that fits in 32 bits, where a design that zero-fills the upper word would leave res_hi at 0, and -2^31 times -1, where a design that checks only the low word would miss the carry. On the divide side, the bench drives dividends of exactly +2^31 and -2^31 by -1 and the most negative 64-bit value by -1. An off-by-one in the quotient range test would trap on the legal case or return a wrapped quotient on the illegal ones. Mixed-sign divides catch a remainder placed with the divisor's sign, and a start pulse injected mid-operation would corrupt the result or shift done if the unit restarted.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdu_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdu_state_e    state;
  logic [CW-1:0] cnt;

  assign load   = start && (state == ST_IDLE);
  assign step   = (state == ST_RUN);
  assign finish = (state == ST_FIN);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a start pulse in the middle of the loop does not reset the step count
  p_count_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start && cnt != LAST) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));

  // R6: completion is a single-cycle pulse
  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mdu_mul_dp.sv
module mdu_mul_dp #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] product,
  output logic           wide
);
  localparam int PW = 2 * W;

  logic [W-1:0] acc_hi, acc_lo, mcand_mag;
  logic         neg;
  logic [W-1:0] a_mag, b_mag;
  logic [W:0]   partial;
  logic [PW-1:0] mag;

  assign a_mag   = mcand_in[W-1]  ? (W'(0) - mcand_in)  : mcand_in;
  assign b_mag   = mplier_in[W-1] ? (W'(0) - mplier_in) : mplier_in;
  assign partial = acc_lo[0] ? ({1'b0, acc_hi} + {1'b0, mcand_mag}) : {1'b0, acc_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi    <= '0;
      acc_lo    <= '0;
      mcand_mag <= '0;
      neg       <= 1'b0;
    end else if (load) begin
      acc_hi    <= '0;
      acc_lo    <= b_mag;
      mcand_mag <= a_mag;
      neg       <= mcand_in[W-1] ^ mplier_in[W-1];
    end else if (step) begin
      {acc_hi, acc_lo} <= {partial, acc_lo[W-1:1]};
    end
  end

  assign mag     = {acc_hi, acc_lo};
  assign product = neg ? (PW'(0) - mag) : mag;
  assign wide    = product[PW-1:W] != {W{product[W-1]}};
endmodule

// File: rtl/mdu_div_dp.sv
module mdu_div_dp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         fault
);
  localparam int DW = 2 * W;

  logic [W-1:0]  rem_r, q_r, dvs_mag;
  logic          big, qneg, rneg;
  logic [DW-1:0] dvd, dvd_mag;
  logic [W-1:0]  dvs_abs;
  logic [W:0]    shifted, diff;
  logic          ge, qfit;

  assign dvd     = {dvd_hi, dvd_lo};
  assign dvd_mag = dvd[DW-1] ? (DW'(0) - dvd) : dvd;
  assign dvs_abs = dvs[W-1] ? (W'(0) - dvs) : dvs;
  assign shifted = {rem_r, q_r[W-1]};
  assign ge      = shifted >= {1'b0, dvs_mag};
  assign diff    = shifted - {1'b0, dvs_mag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r   <= '0;
      q_r     <= '0;
      dvs_mag <= '0;
      big     <= 1'b0;
      qneg    <= 1'b0;
      rneg    <= 1'b0;
    end else if (load) begin
      rem_r   <= dvd_mag[DW-1:W];
      q_r     <= dvd_mag[W-1:0];
      dvs_mag <= dvs_abs;
      big     <= dvd_mag[DW-1:W] >= dvs_abs;
      qneg    <= dvd[DW-1] ^ dvs[W-1];
      rneg    <= dvd[DW-1];
    end else if (step) begin
      rem_r <= ge ? diff[W-1:0] : shifted[W-1:0];
      q_r   <= {q_r[W-2:0], ge};
    end
  end

  assign qfit  = !q_r[W-1] || (qneg && q_r == {1'b1, {(W-1){1'b0}}});
  assign quot  = qneg ? (W'(0) - q_r) : q_r;
  assign rem   = rneg ? (W'(0) - rem_r) : rem_r;
  assign fault = big || !qfit;

  // R3: the partial remainder stays below the divisor on a well-formed divide
  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !big) |=> (rem_r < dvs_mag));
endmodule

// File: rtl/mdu_signed.sv
module mdu_signed
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] src_hi,
  input  logic [W-1:0] src_lo,
  input  logic [W-1:0] src_opd,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_cf,
  output logic         flag_of,
  output logic         div_trap
);
  logic           load, step, finish;
  logic [2*W-1:0] product;
  logic           wide;
  logic [W-1:0]   quot, rem;
  logic           fault;
  mdu_op_e        op_r;

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .step(step),
    .finish(finish), .busy(busy), .done(done)
  );

  mdu_mul_dp #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mcand_in(src_lo), .mplier_in(src_opd), .product(product), .wide(wide)
  );

  mdu_div_dp #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .dvd_hi(src_hi), .dvd_lo(src_lo), .dvs(src_opd),
    .quot(quot), .rem(rem), .fault(fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r     <= OP_MUL;
      res_hi   <= '0;
      res_lo   <= '0;
      flag_cf  <= 1'b0;
      flag_of  <= 1'b0;
      div_trap <= 1'b0;
    end else begin
      div_trap <= 1'b0;
      if (load) op_r <= op_div ? OP_DIV : OP_MUL;
      if (finish) begin
        if (op_r == OP_MUL) begin
          {res_hi, res_lo} <= product;
          flag_cf          <= wide;
          flag_of          <= wide;
        end else if (fault) begin
          div_trap <= 1'b1;
        end else begin
          res_lo <= quot;
          res_hi <= rem;
        end
      end
    end
  end

  // R6: a trap is reported only alongside completion
  p_trap_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_trap |-> done);

  // R6: busy drops exactly when the done pulse appears
  p_busy_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4 and R5: a trapped divide leaves the result words alone
  p_trap_keeps_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_trap) |-> ($stable(res_hi) && $stable(res_lo)));

  // R2: both flags report the same condition
  p_flags_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cf == flag_of);

  // R8: a divide does not touch the flags
  p_div_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_r == OP_DIV) |-> ($stable(flag_cf) && $stable(flag_of)));

  // R8: a multiply never traps
  p_mul_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_r == OP_MUL) |-> !div_trap);
endmodule

// File: tb/tb_mdu_signed.sv
module tb_mdu_signed;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 33;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [31:0] src_hi = '0, src_lo = '0, src_opd = '0;
  logic        busy, done, flag_cf, flag_of, div_trap;
  logic [31:0] res_hi, res_lo;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_tag = "R9";

  // reference model state
  logic        m_busy = 0, m_done = 0, m_trap = 0, m_cf = 0, m_of = 0;
  logic [31:0] m_hi = 0, m_lo = 0;
  int          m_cnt = 0;
  logic        p_div;
  logic [31:0] p_hi, p_lo, p_b;

  mdu_signed dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .src_hi(src_hi), .src_lo(src_lo), .src_opd(src_opd),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
    .flag_cf(flag_cf), .flag_of(flag_of), .div_trap(div_trap)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic model_finish();
    longint a, b, d, p, q, r;
    if (!p_div) begin
      a = longint'($signed(p_lo));
      b = longint'($signed(p_b));
      p = a * b;
      {m_hi, m_lo} = p;
      m_cf = (p != longint'($signed(p[31:0])));
      m_of = m_cf;
    end else begin
      d = longint'({p_hi, p_lo});
      b = longint'($signed(p_b));
      if (b == 0) m_trap = 1;
      else if (d == 64'sh8000000000000000 && b == -1) m_trap = 1;
      else begin
        q = d / b;
        r = d % b;
        if (q > 64'sd2147483647 || q < -64'sd2147483648) m_trap = 1;
        else begin
          m_lo = q[31:0];
          m_hi = r[31:0];
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_trap = 0; m_cf = 0; m_of = 0;
      m_hi = 0; m_lo = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      m_trap = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LATENCY) begin
          m_busy = 0;
          m_done = 1;
          model_finish();
        end
      end else if (start) begin
        m_busy = 1;
        m_cnt  = 0;
        p_div  = op_div;
        p_hi   = src_hi;
        p_lo   = src_lo;
        p_b    = src_opd;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    compared++;
    if (busy !== m_busy || done !== m_done || div_trap !== m_trap ||
        res_hi !== m_hi || res_lo !== m_lo || flag_cf !== m_cf || flag_of !== m_of) begin
      mismatched++;
      $display("FAIL %s busy/done/trap=%b%b%b exp %b%b%b res=%h_%h exp %h_%h cf/of=%b%b exp %b%b",
               cur_tag, busy, done, div_trap, m_busy, m_done, m_trap,
               res_hi, res_lo, m_hi, m_lo, flag_cf, flag_of, m_cf, m_of);
    end
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic run_op(input string tag, input logic dv, input logic [31:0] hi,
                        input logic [31:0] lo, input logic [31:0] b);
    cur_tag = tag;
    @(posedge clk); #2;
    start = 1; op_div = dv; src_hi = hi; src_lo = lo; src_opd = b;
    @(posedge clk); #2;
    start = 0;
    repeat (LATENCY + 1) @(posedge clk);
  endtask

  // R7: a start pulse with other operands arrives while the unit is busy
  task automatic run_with_intrusion(input string tag, input logic dv, input logic [31:0] hi,
                                    input logic [31:0] lo, input logic [31:0] b);
    cur_tag = tag;
    @(posedge clk); #2;
    start = 1; op_div = dv; src_hi = hi; src_lo = lo; src_opd = b;
    @(posedge clk); #2;
    start = 0;
    repeat (10) @(posedge clk);
    #2;
    start = 1; op_div = ~dv; src_hi = 32'h0; src_lo = 32'd7; src_opd = 32'd0;
    @(posedge clk); #2;
    start = 0;
    repeat (LATENCY - 10) @(posedge clk);
    #2;
    start = 1; src_lo = 32'd9; src_opd = 32'd9;
    @(posedge clk); #2;
    start = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    cur_tag = "R9";
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (2) @(posedge clk);

    run_op("R1", 0, 32'h0, 32'hFFFFFFFF, 32'd2);
    run_op("R1", 0, 32'h12345678, 32'hFFFFFFFE, 32'd2);
    run_op("R2", 0, 32'h0, 32'd3, 32'd5);
    run_op("R2", 0, 32'h0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    run_op("R2", 0, 32'h0, 32'h80000000, 32'h80000000);
    run_op("R2", 0, 32'h0, 32'h80000000, 32'hFFFFFFFF);
    run_op("R2", 0, 32'h0, 32'h80000000, 32'd1);
    run_op("R1", 0, 32'h0, 32'd0, 32'hDEADBEEF);
    run_op("R3", 1, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'd2);
    run_op("R3", 1, 32'h0, 32'd100, 32'd7);
    run_op("R3", 1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7);
    run_op("R3", 1, 32'h0, 32'd100, 32'hFFFFFFF9);
    run_op("R3", 1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9);
    run_op("R3", 1, 32'h0, 32'h80000000, 32'hFFFFFFFF);
    run_op("R3", 1, 32'h3, 32'h00000000, 32'h7FFFFFFF);
    run_op("R8", 0, 32'h0, 32'h40000000, 32'd4);
    run_op("R8", 1, 32'h0, 32'd50, 32'd5);
    run_op("R5", 1, 32'h0, 32'd50, 32'd0);
    run_op("R4", 1, 32'h1, 32'h0, 32'd1);
    run_op("R4", 1, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF);
    run_op("R4", 1, 32'h80000000, 32'h0, 32'hFFFFFFFF);
    run_op("R4", 1, 32'h0, 32'h80000000, 32'd1);
    run_with_intrusion("R7", 0, 32'h0, 32'hFFFF0001, 32'h00012345);
    run_with_intrusion("R7", 1, 32'h0, 32'd1000, 32'd33);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 2 == 0) run_op("R1", 0, $urandom, a, b);
      else run_op("R3", 1, {32{a[31]}}, a, (i % 4 == 1) ? {{20{b[31]}}, b[11:0]} : b);
    end

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule